// File: doc/BRIEF.md
# Shared-noise threshold spike trigger

This block produces the 1-bit output spike of each of several neuron models that are evaluated one after another in a prediction round. For every model it receives the accumulated membrane potential. It adds a noise term and compares the sum with a programmable threshold. The spike is set when the sum reaches or exceeds the threshold. It is taken as the inverse of a signed less-than comparison.

The noise term is built from a single Gaussian sample per round. The sample is read from an upstream FIFO with first-word-fall-through behaviour, held for the rest of the round, and scaled by a per-model standard deviation. Each model therefore sees a different noise amplitude while only one random number is consumed.

The block also stores each model's spike and presents the whole set as feedback spikes for the next round. It relays the FIFO's near-full flag back to the generator as a stall. If the FIFO is empty when a round opens, the block keeps the previous sample and raises a sticky underflow flag. The standard deviations and the threshold are written through a small configuration port before prediction starts.

Top module: `noise_spike_trigger`

## Requirements
- R1: For model m, with sample s (signed, NOISE_W bits), standard deviation g_m (unsigned, SIGMA_W bits, SIGMA_FRAC fraction bits) and potential p (signed, POT_W bits), the block computes w = p + ((s * g_m) >>> SIGMA_FRAC) in full precision. `spikeOut` is 1 when w >= theta and 0 when w < theta. Equality gives 1.
- R2: A potential accepted on a clock edge with `potValid` high produces its result on `spikeValid`/`spikeModel`/`spikeOut` two rising edges later. `spikeValid` is high for exactly one cycle per accepted potential, and `spikeOut` is 0 while `spikeValid` is low.
- R3: The model index starts at 0 after reset and advances by one per accepted potential, wrapping from N_MODELS-1 to 0. `spikeModel` reports that index. Idle cycles do not advance it.
- R4: `noiseRdEn` is high, for that cycle only, when a potential for model 0 is presented while `noiseEmpty` is low. It is never high at any other time.
- R5: The sample taken at model 0 (the `noiseData` value in that cycle) is used for every model of that round. Samples that enter the FIFO during the round have no effect until the next round.
- R6: If `noiseEmpty` is high when model 0 is presented, no read is issued and the previous round's sample is reused (0 after reset). `underflowFlag` goes high on the next edge and stays high until reset.
- R7: `feedbackSpikes` bit m holds the spike of model m from the most recently completed round. It is updated on the same edge that outputs the last model's spike, and is all zeros after reset.
- R8: `genHold` equals `noiseNearFull` delayed by one clock.
- R9: A configuration write with `cfgAddr` = m < N_MODELS loads g_m from `cfgData[SIGMA_W-1:0]`. `cfgAddr` = N_MODELS loads theta from `cfgData[POT_W-1:0]` (signed). Writes to any other address change nothing.
- R10: During and right after reset, `spikeValid`, `spikeOut`, `noiseRdEn`, `genHold`, `underflowFlag` and `feedbackSpikes` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgAddr | input | ADDR_W (4) | Configuration address: models 0..N-1, then threshold |
| cfgData | input | CFG_W (24) | Configuration write data |
| potValid | input | 1 | A membrane potential is presented this cycle |
| potential | input | POT_W (24) | Signed membrane potential of the current model |
| noiseData | input | NOISE_W (16) | Head of the noise FIFO, signed |
| noiseEmpty | input | 1 | Noise FIFO is empty |
| noiseRdEn | output | 1 | Pop the noise FIFO head |
| noiseNearFull | input | 1 | Noise FIFO programmable-full flag |
| genHold | output | 1 | Stall request to the noise generator |
| spikeValid | output | 1 | A spike result is presented |
| spikeModel | output | IDX_W (3) | Model index of the presented spike |
| spikeOut | output | 1 | Output spike |
| feedbackSpikes | output | N_MODELS (8) | Spikes of the last completed round, bit per model |
| underflowFlag | output | 1 | Sticky: a round opened with an empty FIFO |

## Verification
A wrong model counter or sample register shows up within one round as spikes that disagree with the scoreboard. The mismatch appears two cycles after the offending potential, because each model's scaled noise sits close to the threshold. A wrong read decision is seen in the same cycle on `noiseRdEn`, and it shifts every later round's sample. Feedback or underflow faults appear at the end of the affected round, or on the edge after an empty-FIFO round start.

// File: rtl/spktrig_pkg.sv
package spktrig_pkg;

  // Strobes sent from the sequencing control to the datapath each cycle.
  typedef struct packed {
    logic capture;     // a potential is accepted this cycle
    logic roundStart;  // the accepted potential belongs to model 0
    logic takeFifo;    // model 0 and the FIFO head is consumed
    logic lastModel;   // the accepted potential closes the round
  } trigStrobe_t;

endpackage

// File: rtl/spktrig_ctrl.sv
module spktrig_ctrl
  import spktrig_pkg::*;
#(
  parameter int N_MODELS = 8,
  parameter int IDX_W    = $clog2(N_MODELS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             potValid,
  input  logic             noiseEmpty,
  input  logic             noiseNearFull,
  output trigStrobe_t      strobe,
  output logic [IDX_W-1:0] modelIdx,
  output logic             noiseRdEn,
  output logic             underflowFlag,
  output logic             genHold
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_MODELS - 1);

  logic isFirst;
  logic isLast;

  assign isFirst = (modelIdx == '0);
  assign isLast  = (modelIdx == LAST_IDX);

  always_comb begin
    strobe.capture    = potValid;
    strobe.roundStart = potValid && isFirst;
    strobe.takeFifo   = potValid && isFirst && !noiseEmpty;
    strobe.lastModel  = potValid && isLast;
  end

  assign noiseRdEn = strobe.takeFifo;

  // Model sequence counter, wraps at the end of each round.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      modelIdx <= '0;
    end else if (potValid) begin
      modelIdx <= isLast ? '0 : modelIdx + 1'b1;
    end
  end

  // Sticky underflow: set when a round opens on an empty FIFO.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      underflowFlag <= 1'b0;
    end else if (strobe.roundStart && noiseEmpty) begin
      underflowFlag <= 1'b1;
    end
  end

  // Registered stall request toward the generator.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      genHold <= 1'b0;
    end else begin
      genHold <= noiseNearFull;
    end
  end

  // R4: the FIFO is never popped while empty.
  assert_no_read_when_empty_R4 : assert property (@(posedge clk) disable iff (!rstN)
    noiseRdEn |-> !noiseEmpty);

  // R4: a read lasts a single cycle, since the counter leaves model 0.
  assert_read_single_cycle_R4 : assert property (@(posedge clk) disable iff (!rstN)
    noiseRdEn |=> !noiseRdEn);

  // R6: once raised, the underflow flag stays raised.
  assert_underflow_sticky_R6 : assert property (@(posedge clk) disable iff (!rstN)
    underflowFlag |=> underflowFlag);

  // R3: the counter is at model 0 right after the last model was accepted.
  assert_wrap_after_last_R3 : assert property (@(posedge clk) disable iff (!rstN)
    strobe.lastModel |=> (modelIdx == '0));

endmodule

// File: rtl/spktrig_datapath.sv
module spktrig_datapath
  import spktrig_pkg::*;
#(
  parameter int N_MODELS   = 8,
  parameter int IDX_W      = $clog2(N_MODELS),
  parameter int ADDR_W     = $clog2(N_MODELS + 1),
  parameter int POT_W      = 24,
  parameter int NOISE_W    = 16,
  parameter int SIGMA_W    = 16,
  parameter int SIGMA_FRAC = 12,
  parameter int CFG_W      = 24
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  trigStrobe_t               strobe,
  input  logic [IDX_W-1:0]          modelIdx,
  input  logic signed [POT_W-1:0]   potential,
  input  logic signed [NOISE_W-1:0] noiseData,
  input  logic                      cfgWrEn,
  input  logic [ADDR_W-1:0]         cfgAddr,
  input  logic [CFG_W-1:0]          cfgData,
  output logic                      spikeValid,
  output logic [IDX_W-1:0]          spikeModel,
  output logic                      spikeOut,
  output logic [N_MODELS-1:0]       feedbackSpikes
);

  localparam int PROD_W = NOISE_W + SIGMA_W + 1;
  localparam int WIDE_W = ((POT_W > PROD_W) ? POT_W : PROD_W) + 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_MODELS - 1);

  // ---------------- configuration registers ----------------
  logic [SIGMA_W-1:0]      sigmaReg [N_MODELS];
  logic signed [POT_W-1:0] thetaReg;

  for (genvar g = 0; g < N_MODELS; g++) begin : g_sigma
    always_ff @(posedge clk) begin
      if (!rstN) begin
        sigmaReg[g] <= '0;
      end else if (cfgWrEn && (cfgAddr == ADDR_W'(g))) begin
        sigmaReg[g] <= cfgData[SIGMA_W-1:0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      thetaReg <= '0;
    end else if (cfgWrEn && (cfgAddr == ADDR_W'(N_MODELS))) begin
      thetaReg <= cfgData[POT_W-1:0];
    end
  end

  // ---------------- shared sample holding ----------------
  logic signed [NOISE_W-1:0] heldSample;
  logic signed [NOISE_W-1:0] roundSample;

  assign roundSample = strobe.takeFifo ? noiseData : heldSample;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      heldSample <= '0;
    end else if (strobe.takeFifo) begin
      heldSample <= noiseData;
    end
  end

  // ---------------- stage 1: operand capture ----------------
  logic                      s1Valid;
  logic                      s1Last;
  logic [IDX_W-1:0]          s1Idx;
  logic signed [POT_W-1:0]   s1Pot;
  logic signed [NOISE_W-1:0] s1Noise;
  logic [SIGMA_W-1:0]        s1Sigma;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      s1Valid <= 1'b0;
      s1Last  <= 1'b0;
      s1Idx   <= '0;
      s1Pot   <= '0;
      s1Noise <= '0;
      s1Sigma <= '0;
    end else begin
      s1Valid <= strobe.capture;
      s1Last  <= strobe.lastModel;
      if (strobe.capture) begin
        s1Idx   <= modelIdx;
        s1Pot   <= potential;
        s1Noise <= roundSample;
        s1Sigma <= sigmaReg[modelIdx];
      end
    end
  end

  // ---------------- stage 2: scale, add, compare ----------------
  logic signed [PROD_W-1:0] noiseExt;
  logic signed [PROD_W-1:0] sigmaExt;
  logic signed [PROD_W-1:0] prod;
  logic signed [PROD_W-1:0] scaled;
  logic signed [WIDE_W-1:0] wSum;
  logic signed [WIDE_W-1:0] thetaWide;
  logic                     belowTheta;
  logic                     spikeNext;
  logic [N_MODELS-1:0]      roundVec;
  logic [N_MODELS-1:0]      nextVec;

  always_comb begin
    noiseExt   = {{(PROD_W - NOISE_W){s1Noise[NOISE_W-1]}}, s1Noise};
    sigmaExt   = {{(PROD_W - SIGMA_W){1'b0}}, s1Sigma};
    prod       = noiseExt * sigmaExt;
    scaled     = prod >>> SIGMA_FRAC;
    wSum       = {{(WIDE_W - POT_W){s1Pot[POT_W-1]}}, s1Pot}
               + {{(WIDE_W - PROD_W){scaled[PROD_W-1]}}, scaled};
    thetaWide  = {{(WIDE_W - POT_W){thetaReg[POT_W-1]}}, thetaReg};
    belowTheta = (wSum < thetaWide);
    spikeNext  = ~belowTheta;
  end

  always_comb begin
    nextVec = roundVec;
    if (s1Valid) begin
      nextVec[s1Idx] = spikeNext;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      spikeValid     <= 1'b0;
      spikeModel     <= '0;
      spikeOut       <= 1'b0;
      roundVec       <= '0;
      feedbackSpikes <= '0;
    end else begin
      spikeValid <= s1Valid;
      spikeOut   <= s1Valid & spikeNext;
      roundVec   <= nextVec;
      if (s1Valid) begin
        spikeModel <= s1Idx;
      end
      if (s1Valid && s1Last) begin
        feedbackSpikes <= nextVec;
      end
    end
  end

  // R2: every captured operand set leaves as one result two edges later.
  assert_result_follows_capture_R2 : assert property (@(posedge clk) disable iff (!rstN)
    s1Valid |=> spikeValid);

  // R2: no spike is reported without a valid result.
  assert_no_spike_without_valid_R2 : assert property (@(posedge clk) disable iff (!rstN)
    spikeOut |-> spikeValid);

  // R5: the held sample changes only after a FIFO read at round start.
  assert_sample_changes_at_round_start_R5 : assert property (@(posedge clk) disable iff (!rstN)
    !$stable(heldSample) |-> $past(strobe.takeFifo));

  // R7: feedback spikes change only together with the last model's result.
  assert_feedback_at_round_end_R7 : assert property (@(posedge clk) disable iff (!rstN)
    !$stable(feedbackSpikes) |-> (spikeValid && (spikeModel == LAST_IDX)));

endmodule

// File: rtl/noise_spike_trigger.sv
module noise_spike_trigger
  import spktrig_pkg::*;
#(
  parameter int N_MODELS   = 8,
  parameter int POT_W      = 24,
  parameter int NOISE_W    = 16,
  parameter int SIGMA_W    = 16,
  parameter int SIGMA_FRAC = 12,
  localparam int IDX_W     = $clog2(N_MODELS),
  localparam int ADDR_W    = $clog2(N_MODELS + 1),
  localparam int CFG_W     = (POT_W > SIGMA_W) ? POT_W : SIGMA_W
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      cfgWrEn,
  input  logic [ADDR_W-1:0]         cfgAddr,
  input  logic [CFG_W-1:0]          cfgData,
  input  logic                      potValid,
  input  logic signed [POT_W-1:0]   potential,
  input  logic signed [NOISE_W-1:0] noiseData,
  input  logic                      noiseEmpty,
  output logic                      noiseRdEn,
  input  logic                      noiseNearFull,
  output logic                      genHold,
  output logic                      spikeValid,
  output logic [IDX_W-1:0]          spikeModel,
  output logic                      spikeOut,
  output logic [N_MODELS-1:0]       feedbackSpikes,
  output logic                      underflowFlag
);

  trigStrobe_t      strobe;
  logic [IDX_W-1:0] modelIdx;

  spktrig_ctrl #(
    .N_MODELS (N_MODELS),
    .IDX_W    (IDX_W)
  ) i_ctrl (
    .clk           (clk),
    .rstN          (rstN),
    .potValid      (potValid),
    .noiseEmpty    (noiseEmpty),
    .noiseNearFull (noiseNearFull),
    .strobe        (strobe),
    .modelIdx      (modelIdx),
    .noiseRdEn     (noiseRdEn),
    .underflowFlag (underflowFlag),
    .genHold       (genHold)
  );

  spktrig_datapath #(
    .N_MODELS   (N_MODELS),
    .IDX_W      (IDX_W),
    .ADDR_W     (ADDR_W),
    .POT_W      (POT_W),
    .NOISE_W    (NOISE_W),
    .SIGMA_W    (SIGMA_W),
    .SIGMA_FRAC (SIGMA_FRAC),
    .CFG_W      (CFG_W)
  ) i_datapath (
    .clk            (clk),
    .rstN           (rstN),
    .strobe         (strobe),
    .modelIdx       (modelIdx),
    .potential      (potential),
    .noiseData      (noiseData),
    .cfgWrEn        (cfgWrEn),
    .cfgAddr        (cfgAddr),
    .cfgData        (cfgData),
    .spikeValid     (spikeValid),
    .spikeModel     (spikeModel),
    .spikeOut       (spikeOut),
    .feedbackSpikes (feedbackSpikes)
  );

endmodule

// File: tb/test_noise_spike_trigger.sv
module test_noise_spike_trigger;

  localparam int N   = 8;
  localparam int FR  = 12;

  logic               clk = 1'b0;
  logic               rstN;
  logic               cfgWrEn;
  logic [3:0]         cfgAddr;
  logic [23:0]        cfgData;
  logic               potValid;
  logic signed [23:0] potential;
  logic signed [15:0] noiseData;
  logic               noiseEmpty;
  logic               noiseRdEn;
  logic               noiseNearFull;
  logic               genHold;
  logic               spikeValid;
  logic [2:0]         spikeModel;
  logic               spikeOut;
  logic [N-1:0]       feedbackSpikes;
  logic               underflowFlag;

  noise_spike_trigger i_noise_spike_trigger (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr), .cfgData(cfgData),
    .potValid(potValid), .potential(potential), .noiseData(noiseData),
    .noiseEmpty(noiseEmpty), .noiseRdEn(noiseRdEn), .noiseNearFull(noiseNearFull),
    .genHold(genHold), .spikeValid(spikeValid), .spikeModel(spikeModel),
    .spikeOut(spikeOut), .feedbackSpikes(feedbackSpikes), .underflowFlag(underflowFlag)
  );

  always #10 clk = ~clk;  // 50 MHz

  typedef struct { int model; bit spike; longint stamp; } item_t;

  item_t  expQ[$];
  int     fifoQ[$];
  int     checks = 0;
  int     fails  = 0;
  longint cyc    = 0;
  bit     finished = 1'b0;

  longint sigmaM [N];
  longint thetaM = 0;
  int     benchIdx = 0;
  longint curSample = 0;
  bit     [N-1:0] buildVec = '0;
  bit     [N-1:0] lastVec  = '0;
  int     seed = 7;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic longint scaledNoise(input longint s, input longint g);
    longint p;
    p = s * g;
    return p >>> FR;
  endfunction

  task automatic refreshFifo();
    noiseEmpty = (fifoQ.size() == 0);
    noiseData  = (fifoQ.size() == 0) ? 16'sd0 : 16'(fifoQ[0]);
  endtask

  task automatic cfgWrite(input int addr, input longint data);
    @(negedge clk);
    refreshFifo();
    cfgWrEn = 1'b1;
    cfgAddr = 4'(addr);
    cfgData = 24'(data);
    @(negedge clk);
    cfgWrEn = 1'b0;
    refreshFifo();
    if (addr < N) sigmaM[addr] = data & 64'hFFFF;
    else if (addr == N) thetaM = longint'($signed(24'(data)));
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      potValid = 1'b0;
      refreshFifo();
    end
  endtask

  // Driver: presents one potential, predicts the FIFO read and the spike.
  task automatic sendPot(input longint pot);
    bit     expRd;
    longint w;
    item_t  it;
    @(negedge clk);
    refreshFifo();
    potValid  = 1'b1;
    potential = 24'(pot);
    expRd = 1'b0;
    if (benchIdx == 0 && fifoQ.size() > 0) begin
      expRd = 1'b1;
      curSample = fifoQ.pop_front();
    end
    #1;
    check(noiseRdEn == expRd, "R4 read enable", noiseRdEn, expRd);
    w = pot + scaledNoise(curSample, sigmaM[benchIdx]);
    it.model = benchIdx;
    it.spike = (w >= thetaM);
    it.stamp = cyc;
    expQ.push_back(it);
    benchIdx = (benchIdx == N - 1) ? 0 : benchIdx + 1;
  endtask

  // Monitor: compares results against the scoreboard queue.
  always @(negedge clk) begin
    if (rstN && !finished) begin
      if (spikeValid) begin
        if (expQ.size() == 0) begin
          check(1'b0, "R2 unexpected result", 1, 0);
        end else begin
          item_t it;
          it = expQ.pop_front();
          check(spikeModel == 3'(it.model), "R3 model index", spikeModel, it.model);
          check(spikeOut == it.spike, "R1 spike value", spikeOut, it.spike);
          check(cyc == it.stamp + 2, "R2 latency", cyc - it.stamp, 2);
          buildVec[it.model] = it.spike;
          if (it.model == N - 1) begin
            lastVec = buildVec;
            check(feedbackSpikes == lastVec, "R7 feedback update", feedbackSpikes, lastVec);
          end else begin
            check(feedbackSpikes == lastVec, "R7 feedback hold", feedbackSpikes, lastVec);
          end
        end
      end else begin
        if (spikeOut !== 1'b0) check(1'b0, "R2 spike without valid", spikeOut, 0);
      end
    end
  end

  function automatic longint nextRand(input int span);
    seed = seed * 1103515245 + 12345;
    return longint'((seed >>> 8) % span);
  endfunction

  initial begin
    rstN = 1'b0; cfgWrEn = 1'b0; cfgAddr = '0; cfgData = '0;
    potValid = 1'b0; potential = '0; noiseNearFull = 1'b0;
    for (int m = 0; m < N; m++) sigmaM[m] = 0;
    refreshFifo();
    repeat (3) @(negedge clk);
    // R10: reset state
    check(spikeValid == 0 && spikeOut == 0, "R10 reset outputs", spikeValid, 0);
    check(noiseRdEn == 0 && genHold == 0, "R10 reset handshake", noiseRdEn, 0);
    check(underflowFlag == 0, "R10 reset underflow", underflowFlag, 0);
    check(feedbackSpikes == 0, "R10 reset feedback", feedbackSpikes, 0);
    rstN = 1'b1;

    // R9: configure sigmas and threshold
    for (int m = 0; m < N; m++) cfgWrite(m, 512 * (m + 1));
    cfgWrite(N, 1000);

    // Round A: sample 1.0, equality on even models, one below on odd (R1, R5)
    fifoQ.push_back(4096);
    fifoQ.push_back(-8192);
    for (int m = 0; m < N; m++) begin
      longint sc;
      sc = scaledNoise(4096, sigmaM[m]);
      sendPot((m % 2 == 0) ? thetaM - sc : thetaM - sc - 1);
    end
    // Round B back to back: negative sample, pseudo-random potentials
    for (int m = 0; m < N; m++) sendPot(nextRand(6000));
    idle(4);
    check(underflowFlag == 0, "R6 no underflow yet", underflowFlag, 0);

    // Round C: FIFO empty, previous sample reused, gaps between models (R6, R3)
    for (int m = 0; m < N; m++) begin
      sendPot(nextRand(9000));
      if (m == 0) begin
        idle(1);
        check(underflowFlag == 1, "R6 underflow set", underflowFlag, 1);
      end
      if (m % 3 == 1) idle(2);
    end
    idle(4);
    check(underflowFlag == 1, "R6 underflow sticky", underflowFlag, 1);

    // R8: near-full relayed one cycle later
    @(negedge clk); noiseNearFull = 1'b1; #1;
    check(genHold == 0, "R8 hold not yet", genHold, 0);
    @(negedge clk);
    check(genHold == 1, "R8 hold raised", genHold, 1);
    noiseNearFull = 1'b0;
    @(negedge clk);
    check(genHold == 0, "R8 hold dropped", genHold, 0);

    // R9: out-of-range writes ignored, then a new negative threshold
    cfgWrite(12, 24'h7FFFFF);
    cfgWrite(N + 1, 24'h000001);
    cfgWrite(N, -300);
    cfgWrite(3, 16'hFFFF);

    // Round D: sample pushed mid-round is not used until the next round (R5)
    fifoQ.push_back(3000);
    for (int m = 0; m < N; m++) begin
      sendPot(nextRand(4000));
      if (m == 2) fifoQ.push_back(-20000);
    end
    // Round E uses the later sample
    for (int m = 0; m < N; m++) sendPot(nextRand(30000));
    idle(5);
    check(expQ.size() == 0, "R2 all results seen", expQ.size(), 0);
    check(fifoQ.size() == 0, "R4 one read per round", fifoQ.size(), 0);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule